// File: doc/BRIEF.md
# Sequencer Instruction Memory Load Port

This block lets a host load and inspect a 32-bit-wide sequencer instruction memory through an 8-bit register interface. A host sets a 9-bit instruction index through two index registers. It then streams bytes through a single data port. Four byte accesses make up one instruction word. An internal lane counter chooses which byte of the word each access touches. The instruction index moves to the next word only after the top byte.

A control register holds three bits: a load enable that gates writes into the memory, a sequencer reset, and a single-step request. These bits are driven out to the sequencer core. The memory also has an independent fetch port that the sequencer core uses to read whole instruction words.

Top module: `seqram_window`

## Requirements
- R1: After reset the control register, both index registers and the lane counter are zero, and the load, reset and step outputs are low.
- R2: A write to offset 0x60 stores bit 0 as load enable, bit 1 as sequencer reset and bit 2 as single step. These appear on the outputs from the next cycle. A read of 0x60 returns those three bits with bits 7..3 zero.
- R3: Offset 0x62 holds index bits 7..0. Offset 0x63 holds index bit 8 in its bit 0. A read of 0x63 returns only that bit, with bits 7..1 zero.
- R4: With load enable set, four writes to offset 0x61 fill the word at the current index starting at the least significant byte. The word is then visible on the fetch port.
- R5: The index advances by one after the fourth, most significant byte access of a word and stays unchanged after the first three.
- R6: While load enable is clear, writes to 0x61 change neither the memory, the lane counter nor the index.
- R7: Any write to 0x62 or 0x63 returns the lane counter to byte 0.
- R8: Reads of 0x61 return the byte of the current word selected by the lane counter, least significant first. They advance the lane counter and the index exactly as writes do, whether or not load enable is set.
- R9: Advancing past index 511 wraps to index 0.
- R10: Writes to any other offset change nothing, and reads of any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current access (combinational) |
| seq_load_en | output | 1 | Load enable bit |
| seq_reset | output | 1 | Sequencer reset bit |
| seq_step | output | 1 | Single-step bit |
| fetch_idx | input | 9 | Sequencer fetch index |
| fetch_word | output | 32 | Instruction word at fetch_idx |

## Verification
Words are loaded with four distinct byte values so that a byte-order or lane error shows up as a permuted word on the fetch port. The index is read back after three bytes and again after four, which separates advancing too early from never advancing. A partial word followed by an index rewrite shows whether the lane counter clears. A data write with loading disabled, placed between two known memory states, shows any leak of that write into memory or into the counters. Streaming reads of a stored word, a load at index 511, and accesses to an unmapped offset cover readback order, wrap-around and decode.

// File: rtl/seqram_pkg.sv
package seqram_pkg;
    localparam logic [7:0] OFS_CTRL   = 8'h60;
    localparam logic [7:0] OFS_DATA   = 8'h61;
    localparam logic [7:0] OFS_IDX_LO = 8'h62;
    localparam logic [7:0] OFS_IDX_HI = 8'h63;

    localparam int unsigned CTRL_BITS = 3;

    // bit 0 load enable, bit 1 sequencer reset, bit 2 single step
    typedef struct packed {
        logic step;
        logic rst;
        logic load;
    } ctrl_t;
endpackage

// File: rtl/seqram_ctl.sv
module seqram_ctl
    import seqram_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wdata,
    output ctrl_t             ctl
);
    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr) ctl_d = ctrl_t'(wdata[CTRL_BITS-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign ctl = ctl_q;

    // R2
    p_ctrl_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (ctl_q == ctrl_t'($past(wdata[CTRL_BITS-1:0]))));
endmodule

// File: rtl/seqram_ptr.sv
module seqram_ptr #(
    parameter int unsigned IDX_W      = 9,
    parameter int unsigned BYTE_W     = 8,
    parameter int unsigned WORD_BYTES = 4,
    localparam int unsigned LANE_W    = $clog2(WORD_BYTES),
    localparam int unsigned HI_W      = IDX_W - BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              adv,
    output logic [IDX_W-1:0]  idx,
    output logic [LANE_W-1:0] lane
);
    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(WORD_BYTES - 1);

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [LANE_W-1:0] lane;
    } ptr_t;

    ptr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_lo) begin
            s_d.idx[BYTE_W-1:0] = wdata;
            s_d.lane            = '0;
        end else if (wr_hi) begin
            s_d.idx[IDX_W-1:BYTE_W] = wdata[HI_W-1:0];
            s_d.lane                = '0;
        end else if (adv) begin
            if (s_q.lane == LAST_LANE) begin
                s_d.lane = '0;
                s_d.idx  = s_q.idx + 1'b1;
            end else begin
                s_d.lane = s_q.lane + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign idx  = s_q.idx;
    assign lane = s_q.lane;

    // R5 and R9: the top byte moves the index by one, modulo the depth
    p_word_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr_lo && !wr_hi && s_q.lane == LAST_LANE)
            |=> (s_q.idx == $past(s_q.idx) + 1'b1));

    // R5: lower bytes keep the index
    p_word_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr_lo && !wr_hi && s_q.lane != LAST_LANE) |=> $stable(s_q.idx));

    // R7
    p_lane_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo || wr_hi) |=> (s_q.lane == '0));
endmodule

// File: rtl/seqram_store.sv
module seqram_store #(
    parameter int unsigned IDX_W      = 9,
    parameter int unsigned BYTE_W     = 8,
    parameter int unsigned WORD_BYTES = 4,
    localparam int unsigned LANE_W    = $clog2(WORD_BYTES),
    localparam int unsigned WORD_W    = BYTE_W * WORD_BYTES,
    localparam int unsigned DEPTH     = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [LANE_W-1:0] lane,
    input  logic [BYTE_W-1:0] wbyte,
    output logic [BYTE_W-1:0] rbyte,
    input  logic [IDX_W-1:0]  fetch_idx,
    output logic [WORD_W-1:0] fetch_word
);
    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[idx][lane*BYTE_W +: BYTE_W] <= wbyte;
    end

    assign rbyte      = mem_q[idx][lane*BYTE_W +: BYTE_W];
    assign fetch_word = mem_q[fetch_idx];
endmodule

// File: rtl/seqram_window.sv
module seqram_window
    import seqram_pkg::*;
#(
    parameter int unsigned IDX_W      = 9,
    parameter int unsigned BYTE_W     = 8,
    parameter int unsigned WORD_BYTES = 4,
    localparam int unsigned LANE_W    = $clog2(WORD_BYTES),
    localparam int unsigned WORD_W    = BYTE_W * WORD_BYTES,
    localparam int unsigned HI_W      = IDX_W - BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [7:0]        bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              seq_load_en,
    output logic              seq_reset,
    output logic              seq_step,
    input  logic [IDX_W-1:0]  fetch_idx,
    output logic [WORD_W-1:0] fetch_word
);
    ctrl_t             ctl;
    logic [IDX_W-1:0]  idx;
    logic [LANE_W-1:0] lane;
    logic [BYTE_W-1:0] rbyte;
    logic              wr_ctl, wr_lo, wr_hi, data_hit, data_adv, mem_we;

    always_comb begin
        wr_ctl   = bus_en && bus_we && (bus_addr == OFS_CTRL);
        wr_lo    = bus_en && bus_we && (bus_addr == OFS_IDX_LO);
        wr_hi    = bus_en && bus_we && (bus_addr == OFS_IDX_HI);
        data_hit = bus_en && (bus_addr == OFS_DATA);
        mem_we   = data_hit && bus_we && ctl.load;
        data_adv = data_hit && (!bus_we || ctl.load);
    end

    seqram_ctl #(.BYTE_W(BYTE_W)) ctl_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_ctl),
        .wdata (bus_wdata),
        .ctl   (ctl)
    );

    seqram_ptr #(.IDX_W(IDX_W), .BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES)) ptr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_lo (wr_lo),
        .wr_hi (wr_hi),
        .wdata (bus_wdata),
        .adv   (data_adv),
        .idx   (idx),
        .lane  (lane)
    );

    seqram_store #(.IDX_W(IDX_W), .BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES)) store_i (
        .clk        (clk),
        .we         (mem_we),
        .idx        (idx),
        .lane       (lane),
        .wbyte      (bus_wdata),
        .rbyte      (rbyte),
        .fetch_idx  (fetch_idx),
        .fetch_word (fetch_word)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_en && !bus_we) begin
            unique case (bus_addr)
                OFS_CTRL:   bus_rdata = BYTE_W'(ctl);
                OFS_DATA:   bus_rdata = rbyte;
                OFS_IDX_LO: bus_rdata = idx[BYTE_W-1:0];
                OFS_IDX_HI: bus_rdata = BYTE_W'(idx[IDX_W-1:BYTE_W]);
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign seq_load_en = ctl.load;
    assign seq_reset   = ctl.rst;
    assign seq_step    = ctl.step;

    // R6: a blocked data write leaves the pointer alone
    p_blocked_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && bus_addr == OFS_DATA && !seq_load_en)
            |=> ($stable(idx) && $stable(lane)));
endmodule

// File: tb/seqram_window_tb.sv
module seqram_window_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0, bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        seq_load_en, seq_reset, seq_step;
    logic [8:0]  fetch_idx = '0;
    logic [31:0] fetch_word;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seqram_window dut_i (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .seq_load_en(seq_load_en), .seq_reset(seq_reset), .seq_step(seq_step),
        .fetch_idx(fetch_idx), .fetch_word(fetch_word)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic set_idx(input logic [8:0] i);
        wr(8'h62, i[7:0]);
        wr(8'h63, {7'b0, i[8]});
    endtask

    task automatic load_word(input logic [31:0] w);
        for (int b = 0; b < 4; b++) wr(8'h61, w[b*8 +: 8]);
    endtask

    task automatic fetch(input logic [8:0] i, output logic [31:0] w);
        @(negedge clk);
        fetch_idx = i;
        #1 w = fetch_word;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 load", {31'b0, seq_load_en}, 32'd0);
        check("R1 reset", {31'b0, seq_reset}, 32'd0);
        check("R1 step", {31'b0, seq_step}, 32'd0);
        rd(8'h60, d); check("R1 ctrl", {24'b0, d}, 32'h0);
        rd(8'h62, d); check("R1 idx lo", {24'b0, d}, 32'h0);
        rd(8'h63, d); check("R1 idx hi", {24'b0, d}, 32'h0);
    endtask

    task automatic t_ctrl();
        logic [7:0] d;
        wr(8'h60, 8'hFF);
        check("R2 outs", {29'b0, seq_step, seq_reset, seq_load_en}, 32'h7);
        rd(8'h60, d); check("R2 readback", {24'b0, d}, 32'h07);
        wr(8'h60, 8'h01);
        check("R2 load only", {29'b0, seq_step, seq_reset, seq_load_en}, 32'h1);
    endtask

    task automatic t_idx();
        logic [7:0] d;
        wr(8'h62, 8'hA5);
        wr(8'h63, 8'hFF);
        rd(8'h62, d); check("R3 lo", {24'b0, d}, 32'hA5);
        rd(8'h63, d); check("R3 hi", {24'b0, d}, 32'h01);
    endtask

    task automatic t_load();
        logic [7:0] d; logic [31:0] w;
        set_idx(9'd5);
        wr(8'h61, 8'h11); wr(8'h61, 8'h22); wr(8'h61, 8'h33);
        rd(8'h62, d); check("R5 hold after 3", {24'b0, d}, 32'd5);
        wr(8'h61, 8'h44);
        rd(8'h62, d); check("R5 step after 4", {24'b0, d}, 32'd6);
        fetch(9'd5, w); check("R4 word", w, 32'h44332211);
    endtask

    task automatic t_blocked();
        logic [7:0] d; logic [31:0] w;
        set_idx(9'd6);
        load_word(32'h01020304);
        set_idx(9'd6);
        wr(8'h60, 8'h00);
        wr(8'h61, 8'hEE);
        fetch(9'd6, w); check("R6 mem kept", w, 32'h01020304);
        rd(8'h62, d); check("R6 idx kept", {24'b0, d}, 32'd6);
        wr(8'h60, 8'h01);
        wr(8'h61, 8'h55);
        fetch(9'd6, w); check("R6 lane kept", w, 32'h01020355);
    endtask

    task automatic t_lane_clear();
        logic [7:0] d; logic [31:0] w;
        set_idx(9'd10);
        wr(8'h61, 8'h77); wr(8'h61, 8'h88);
        wr(8'h62, 8'd10);
        load_word(32'hA4A3A2A1);
        fetch(9'd10, w); check("R7 word", w, 32'hA4A3A2A1);
        rd(8'h62, d); check("R7 idx", {24'b0, d}, 32'd11);
    endtask

    task automatic t_read();
        logic [7:0] d;
        wr(8'h60, 8'h00);
        set_idx(9'd5);
        for (int b = 0; b < 4; b++) begin
            rd(8'h61, d);
            check("R8 byte", {24'b0, d}, 32'h11 * (b + 1));
        end
        rd(8'h62, d); check("R8 idx", {24'b0, d}, 32'd6);
        wr(8'h60, 8'h01);
    endtask

    task automatic t_wrap();
        logic [7:0] d; logic [31:0] w;
        set_idx(9'd511);
        load_word(32'hCAFEF00D);
        rd(8'h62, d); check("R9 lo", {24'b0, d}, 32'h0);
        rd(8'h63, d); check("R9 hi", {24'b0, d}, 32'h0);
        fetch(9'd511, w); check("R9 word", w, 32'hCAFEF00D);
    endtask

    task automatic t_other();
        logic [7:0] d;
        wr(8'h70, 8'hFF);
        rd(8'h70, d); check("R10 read zero", {24'b0, d}, 32'h0);
        rd(8'h60, d); check("R10 ctrl kept", {24'b0, d}, 32'h01);
        rd(8'h62, d); check("R10 idx kept", {24'b0, d}, 32'h0);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_idx();
        t_load();
        t_blocked();
        t_lane_clear();
        t_read();
        t_wrap();
        t_other();
        finished = 1'b1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end
endmodule